// File: doc/BRIEF.md
# Binary Tree Up/Down Route Unit

The unit makes routing decisions for packets in a binary tree or fat-tree network whose leaves carry `ADDR_W`-bit addresses. Each address lists the left/right choices that lead down from the root, so the tree has `ADDR_W` switch levels above the leaves. For a source leaf A and a destination leaf B, the unit finds the highest bit position in which the two addresses differ. The packet must climb one level more than that bit index to reach the lowest common ancestor. It then descends, taking one bit of B per level as the child choice, from that index down to bit 0.

Every accepted request returns two sets of results. The first set supports source-side header building: a local-delivery flag, the climb count and the masked downward bits of B. The second set is a per-switch next-port decision. It is based on the level of the switch asking (level 0 is the leaf itself) and the remaining up-count carried in the header. The response is registered and handed back over a valid/ready pair, one cycle after the request is accepted.

Top module: `tree_route_unit`

## Requirements
- R1: When `src_i == dst_i`, the response has `local_o = 1`, `climb_o = 0` and `down_bits_o = 0`. Otherwise `local_o = 0`.
- R2: `climb_o` equals one plus the index of the most significant set bit of `src_i ^ dst_i`.
- R3: `down_bits_o` holds `dst_i` bits `climb_o-1` down to 0 in place, with all higher bits zero. The descent consumes these bits most significant first.
- R4: When `up_cnt_i != 0`, `port_o` is UP (encoding 2'b10) and `cnt_o = up_cnt_i - 1`, at any level.
- R5: When `up_cnt_i == 0` and `level_i = L` with 1 ≤ L ≤ `ADDR_W`, `port_o` is LEFT (2'b00) if `dst_i[L-1]` is 0 and RIGHT (2'b01) if it is 1. In this case `cnt_o = 0`.
- R6: When `up_cnt_i == 0` and `level_i == 0`, `port_o` is LOCAL (2'b11), meaning delivery at this leaf, and `cnt_o = 0`.
- R7: A request accepted at a clock edge (`req_valid_i && req_ready_o`) gives `rsp_valid_o = 1` right after that edge.
- R8: While `rsp_valid_o && !rsp_ready_i`, all response outputs hold their values, `req_ready_o` is 0, and any new request is not taken.
- R9: After reset, `rsp_valid_o = 0` and `req_ready_o = 1`.
- R10: Suppose a packet starts at leaf A at level 0 with `up_cnt = climb_o`, and each hop applies the per-switch decision, where UP raises the level and a child port lowers it and fixes one address bit. The packet then reaches leaf B after exactly `2*climb_o` hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| src_i | input | ADDR_W | Source leaf address |
| dst_i | input | ADDR_W | Destination leaf address |
| level_i | input | LVL_W | Level of the asking switch, 0 = leaf |
| up_cnt_i | input | LVL_W | Remaining upward hops from the header |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed when high with valid |
| local_o | output | 1 | Source and destination are the same leaf |
| climb_o | output | LVL_W | Levels to climb to the common ancestor |
| down_bits_o | output | ADDR_W | Destination bits used on the way down, upper bits zero |
| port_o | output | 2 | Next port: 00 left, 01 right, 10 up, 11 local |
| cnt_o | output | LVL_W | Up-count to forward with the packet |

## Verification
The bench sweeps all 256 source/destination pairs of a 4-bit tree and walks each packet hop by hop to its leaf. A wrong leading-one search would climb one level short or one level too far. Climbing short sends the packet down the wrong subtree, so the final address misses B. Climbing too far makes the hop count exceed twice the climb. The equal-address pairs target a design that fails to flag local delivery or emits a stray hop. The level-to-bit mapping is checked at every level, including the root, where an off-by-one index would pick the wrong child. A held response under backpressure, with a competing request on the input, catches a register that overwrites or drops its data.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
  typedef enum logic [1:0] {
    PORT_LEFT  = 2'b00,
    PORT_RIGHT = 2'b01,
    PORT_UP    = 2'b10,
    PORT_LOCAL = 2'b11
  } port_e;
endpackage

// File: rtl/lead_one_lvl.sv
// Position of the leading one, returned as a 1-based count (0 when vector is zero).
module lead_one_lvl #(
  parameter int W     = 4,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] lvl_o,
  output logic             any_o
);
  always_comb begin
    lvl_o = '0;
    for (int j = 0; j < W; j++) begin
      if (vec_i[j]) lvl_o = CNT_W'(j + 1);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/route_source.sv
module route_source #(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              local_o,
  output logic [LVL_W-1:0]  climb_o,
  output logic [ADDR_W-1:0] down_bits_o
);
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] keep_mask;
  logic              differs;

  assign diff = src_i ^ dst_i;

  lead_one_lvl #(
    .W    (ADDR_W),
    .CNT_W(LVL_W)
  ) u_lead (
    .vec_i(diff),
    .lvl_o(climb_o),
    .any_o(differs)
  );

  generate
    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
      assign keep_mask[g] = (LVL_W'(g) < climb_o);
    end
  endgenerate

  assign local_o     = ~differs;
  assign down_bits_o = dst_i & keep_mask;
endmodule

// File: rtl/route_hop.sv
module route_hop
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [LVL_W-1:0]  up_cnt_i,
  output port_e             port_o,
  output logic [LVL_W-1:0]  cnt_o
);
  logic child_bit;

  // switch at level L steers with destination bit L-1
  always_comb begin
    child_bit = 1'b0;
    for (int j = 0; j < ADDR_W; j++) begin
      if (level_i == LVL_W'(j + 1)) child_bit = dst_i[j];
    end
  end

  always_comb begin
    if (up_cnt_i != '0) begin
      port_o = PORT_UP;
      cnt_o  = up_cnt_i - LVL_W'(1);
    end else if (level_i == '0) begin
      port_o = PORT_LOCAL;
      cnt_o  = '0;
    end else begin
      port_o = child_bit ? PORT_RIGHT : PORT_LEFT;
      cnt_o  = '0;
    end
  end
endmodule

// File: rtl/route_out_reg.sv
module route_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_ready_o = ~valid_q | out_ready_i;
  assign take       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (take) data_q <= in_data_i;
      valid_q <= take | (valid_q & ~out_ready_i);
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r8_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  a_r8_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [LVL_W-1:0]  up_cnt_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              local_o,
  output logic [LVL_W-1:0]  climb_o,
  output logic [ADDR_W-1:0] down_bits_o,
  output logic [1:0]        port_o,
  output logic [LVL_W-1:0]  cnt_o
);
  localparam int DW = 1 + LVL_W + ADDR_W + 2 + LVL_W;

  logic              src_local;
  logic [LVL_W-1:0]  src_climb;
  logic [ADDR_W-1:0] src_bits;
  port_e             hop_port;
  logic [LVL_W-1:0]  hop_cnt;
  logic [DW-1:0]     pack_d;
  logic [DW-1:0]     pack_q;

  route_source #(
    .ADDR_W(ADDR_W),
    .LVL_W (LVL_W)
  ) u_source (
    .src_i      (src_i),
    .dst_i      (dst_i),
    .local_o    (src_local),
    .climb_o    (src_climb),
    .down_bits_o(src_bits)
  );

  route_hop #(
    .ADDR_W(ADDR_W),
    .LVL_W (LVL_W)
  ) u_hop (
    .dst_i   (dst_i),
    .level_i (level_i),
    .up_cnt_i(up_cnt_i),
    .port_o  (hop_port),
    .cnt_o   (hop_cnt)
  );

  assign pack_d = {src_local, src_climb, src_bits, hop_port, hop_cnt};

  route_out_reg #(
    .W(DW)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (req_valid_i),
    .in_ready_o (req_ready_o),
    .in_data_i  (pack_d),
    .out_valid_o(rsp_valid_o),
    .out_ready_i(rsp_ready_i),
    .out_data_o (pack_q)
  );

  assign {local_o, climb_o, down_bits_o, port_o, cnt_o} = pack_q;

  a_r1_local_no_climb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && local_o) |-> (climb_o == '0 && down_bits_o == '0));

  a_r1_climb_not_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !local_o) |-> (climb_o != '0));

  a_r2_climb_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (climb_o <= LVL_W'(ADDR_W)));

  a_r3_bits_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ((down_bits_o >> climb_o) == '0));

  a_r4_down_has_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && port_o != 2'b10) |-> (cnt_o == '0));
endmodule

// File: tb/tree_route_unit_bench.sv
module tree_route_unit_bench;
  localparam int AW = 4;
  localparam int LW = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] src = '0;
  logic [AW-1:0] dst = '0;
  logic [LW-1:0] level = '0;
  logic [LW-1:0] up_cnt = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          loc;
  logic [LW-1:0] climb;
  logic [AW-1:0] dbits;
  logic [1:0]    port;
  logic [LW-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tree_route_unit #(.ADDR_W(AW)) u_tree_route_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .src_i(src), .dst_i(dst), .level_i(level), .up_cnt_i(up_cnt),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .local_o(loc), .climb_o(climb), .down_bits_o(dbits),
    .port_o(port), .cnt_o(cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int a, input int b, input int lvl, input int uc);
    @(negedge clk);
    src = AW'(a); dst = AW'(b); level = LW'(lvl); up_cnt = LW'(uc);
    req_valid = 1'b1;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7 response valid one cycle after accept", int'(rsp_valid), 1);
  endtask

  function automatic int ref_climb(input int a, input int b);
    int r = (a ^ b) & ((1 << AW) - 1);
    int c = 0;
    for (int j = 0; j < AW; j++) if ((r >> j) & 1) c = j + 1;
    return c;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp_valid in reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R9 req_ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", int'(rsp_valid), 0);

    for (int a = 0; a < (1 << AW); a++) begin
      for (int b = 0; b < (1 << AW); b++) begin
        int ec;
        int lvl;
        int uc;
        int pos;
        int hops;
        int steps;
        bit fin;
        ec = ref_climb(a, b);
        send(a, b, 0, ec);
        chk(int'(loc) == int'(a == b), "R1 local flag", int'(loc), int'(a == b));
        chk(int'(climb) == ec, "R2 climb count", int'(climb), ec);
        chk(int'(dbits) == (b & ((1 << ec) - 1)), "R3 down bits", int'(dbits),
            b & ((1 << ec) - 1));
        if (a == b)
          chk(port == 2'b11, "R6 local at leaf", int'(port), 3);
        // hop-by-hop walk
        lvl = 0; uc = ec; pos = a; hops = 0; steps = 0; fin = 1'b0;
        while (!fin && steps < 3 * AW + 2) begin
          int ep;
          int en;
          steps++;
          send(a, b, lvl, uc);
          if (uc != 0) begin ep = 2; en = uc - 1; end
          else if (lvl == 0) begin ep = 3; en = 0; end
          else begin ep = (b >> (lvl - 1)) & 1; en = 0; end
          if (ep == 2) chk(int'(port) == ep && int'(cnt) == en, "R4 up decision",
                           int'(port) * 16 + int'(cnt), ep * 16 + en);
          else if (ep == 3) chk(int'(port) == ep && int'(cnt) == en, "R6 leaf decision",
                                int'(port) * 16 + int'(cnt), ep * 16 + en);
          else chk(int'(port) == ep && int'(cnt) == en, "R5 down decision",
                   int'(port) * 16 + int'(cnt), ep * 16 + en);
          case (port)
            2'b10: begin lvl++; uc = int'(cnt); hops++; end
            2'b11: fin = 1'b1;
            default: begin
              lvl--;
              if (lvl < 0) lvl = 0;
              pos = (pos & ~(1 << lvl)) | (int'(port[0]) << lvl);
              uc = int'(cnt);
              hops++;
            end
          endcase
        end
        chk(fin && pos == b, "R10 walk reaches destination", pos, b);
        chk(hops == 2 * ec, "R10 hop count", hops, 2 * ec);
      end
    end

    // backpressure
    @(negedge clk);
    src = 4'h3; dst = 4'hC; level = '0; up_cnt = 3'd4;
    req_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 valid under backpressure", int'(rsp_valid), 1);
    chk(int'(climb) == 4, "R2 climb 3 vs 12", int'(climb), 4);
    src = 4'h5; dst = 4'h5; up_cnt = '0;
    repeat (2) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 req_ready low while stalled", int'(req_ready), 0);
      chk(rsp_valid == 1'b1 && int'(climb) == 4 && loc == 1'b0 && int'(dbits) == 12,
          "R8 held response", int'(climb), 4);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1 && loc == 1'b1 && climb == '0, "R8 next request after release",
        int'(loc), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 drained", int'(rsp_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule